// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a DDR SDRAM interface. On every rising clock edge it samples clock enable, chip select, the three active-low command strobes, the bank select and the address bus. From these it decodes the command and checks it against the state of the bank it targets. Commands that pass are reported to the data-path logic as a registered strobe, together with the target bank, row, column and the precharge flags. The block keeps the open row of each bank. It also holds the base and extended mode registers and presents the burst length as a plain number.

Each bank has its own small state machine. It has three states. `BK_IDLE` means no row is open. `BK_OPEN` means a row is open and usable. `BK_AP_WAIT` means a read or write asked for auto-precharge, and the bank waits for its burst to drain.

The transitions are as follows:
- *activate*: `BK_IDLE`→`BK_OPEN` on an accepted ACTIVE.
- *close*: `BK_OPEN`/`BK_AP_WAIT`→`BK_IDLE` on a PRECHARGE that names the bank, or on a PRECHARGE to all banks.
- *arm*: `BK_OPEN`→`BK_AP_WAIT` on a READ or WRITE with A10 high.
- *drain*: `BK_AP_WAIT`→`BK_IDLE` when the burst counter expires.

All other cases stay in place.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: Inputs are sampled only on the rising edge of `clk_i`. An accepted command appears on the outputs after that same edge: `cmd_vld_o`=1, `cmd_o` = code, `bank_o` = `ba_i`. Outputs hold zero on cycles without an accepted command.
- R2: With `cs_ni` high at the edge, nothing is decoded. `cmd_vld_o` and `err_o` stay 0, and no bank or mode state changes.
- R3: With `cke_i` low at the edge, nothing is decoded. Bank states, rows and auto-precharge counters are frozen for that edge.
- R4: Encoding of {ras_n,cas_n,we_n} maps to `cmd_o` as follows: 011 ACTIVE→1, 101 READ→2, 100 WRITE→3, 010 PRECHARGE→4, 001 AUTO REFRESH→5, 000 LOAD MODE→6. Both 111 and 110 are no operation and give no strobe.
- R5: ACTIVE to an idle bank opens it, sets `open_o[bank]`, stores `addr_i` as the bank's row and reports it on `row_o`.
- R6: READ/WRITE to an open bank reports the bank's stored row on `row_o` and A10 on `auto_pre_o`. The column on `col_o` (11 bits) is {0,A[9:0]}, or {A11,A[9:0]} when `cfg_wide_col_i` is 1.
- R7: PRECHARGE with A10=0 closes only bank `ba_i`. With A10=1 it closes all banks, and `pre_all_o` is set to 1.
- R8: READ/WRITE with A10=1 closes its bank on the edge burst_length/2 cycles after the command edge. Before that, a READ/WRITE or ACTIVE to that bank is rejected.
- R9: A rejected command gives `err_o`=1 for one cycle with `cmd_vld_o`=0 and changes no state. Two cases are rejected here: a READ/WRITE to a bank not in the open state, and an ACTIVE to a bank that is not idle.
- R10: LOAD MODE with `ba_i`=00 writes `addr_i` to `mode_o`. With `ba_i`=01 it writes to `ext_mode_o`. With `ba_i`=1x it is rejected as in R9.
- R11: `burst_len_o` follows `mode_o[2:0]`: 001→2, 010→4, 011→8. A base-register load whose field holds any other code is rejected and leaves `mode_o` unchanged.
- R12: After reset, all banks are closed, all strobes are 0, `mode_o`=13'h0001 (burst 2) and `ext_mode_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low suspends decoding |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select / mode register select |
| addr_i | input | 13 | Row, column+A10, or op-code |
| cfg_wide_col_i | input | 1 | Column uses A11 as its top bit |
| cmd_vld_o | output | 1 | Accepted-command strobe |
| cmd_o | output | 3 | Accepted command code |
| bank_o | output | 2 | Target bank |
| row_o | output | 13 | Target row |
| col_o | output | 11 | Target column |
| auto_pre_o | output | 1 | Read/write asked for auto-precharge |
| pre_all_o | output | 1 | Precharge applied to all banks |
| err_o | output | 1 | Command rejected |
| open_o | output | 4 | Per-bank row-open flags |
| burst_len_o | output | 4 | Burst length in beats |
| mode_o | output | 13 | Base mode register |
| ext_mode_o | output | 13 | Extended mode register |

## Verification
The assertions check several rules on every cycle:
- A bank only rises to open on an accepted ACTIVE.
- Deselected or clock-disabled edges never produce a strobe, and clock-disabled edges leave the open flags unchanged.
- The strobe and the error never coincide.
- The burst length is always 2, 4 or 8.
- The bank machines only receive an activate while idle, or an arm while open.

Some behaviour is visible only in the bench scenarios:
- the row and column fields carried through;
- the exact edge on which an auto-precharge drains for each burst length;
- the counter freezing under a low clock enable;
- which of the two mode registers a load reaches.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_LMR = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_AP_WAIT = 2'd2
    } bank_st_e;

    function automatic logic bl_code_ok(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction

    function automatic logic [3:0] bl_beats(input logic [2:0] code);
        logic [3:0] beats;
        unique case (code)
            3'd2:    beats = 4'd4;
            3'd3:    beats = 4'd8;
            default: beats = 4'd2;
        endcase
        return beats;
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cke_i,
    input  logic cs_ni,
    input  logic ras_ni,
    input  logic cas_ni,
    input  logic we_ni,
    output cmd_e cmd_o
);

    always_comb begin
        cmd_o = CMD_NOP;
        if (cke_i && !cs_ni) begin
            unique case ({ras_ni, cas_ni, we_ni})
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                3'b000:  cmd_o = CMD_LMR;
                default: cmd_o = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
    import ddr_cmd_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             act_i,
    input  logic             arm_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [CNT_W-1:0] drain_i,
    output logic             idle_o,
    output logic             ready_o,
    output logic [ROW_W-1:0] row_o
);

    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ROW_W-1:0] row_q, row_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        row_d = row_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_i) begin
                    st_d  = BK_OPEN;
                    row_d = row_i;
                end
            end
            BK_OPEN: begin
                if (pre_i) begin
                    st_d = BK_IDLE;
                end else if (arm_i) begin
                    st_d  = BK_AP_WAIT;
                    cnt_d = drain_i;
                end
            end
            BK_AP_WAIT: begin
                if (pre_i) begin
                    st_d = BK_IDLE;
                end else if (tick_i) begin
                    if (cnt_q == CNT_W'(1)) begin
                        st_d = BK_IDLE;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            row_q <= row_d;
        end
    end

    always_comb begin
        idle_o  = (st_q == BK_IDLE);
        ready_o = (st_q == BK_OPEN);
        row_o   = row_q;
    end

    // R9: the top must never activate a bank that is not idle
    assert_act_only_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_i |-> (st_q == BK_IDLE));

    // R8: auto-precharge may only be armed from the open state
    assert_arm_only_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |-> (st_q == BK_OPEN));

    // R8: a draining bank always has a live counter
    assert_drain_count_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == BK_AP_WAIT) |-> (cnt_q != '0));

endmodule

// File: rtl/ddr_mode_file.sv
module ddr_mode_file
    import ddr_cmd_pkg::*;
#(
    parameter int MR_W = 13
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [1:0]      sel_i,
    input  logic [MR_W-1:0] op_i,
    output logic            ok_o,
    output logic [MR_W-1:0] mode_o,
    output logic [MR_W-1:0] ext_o,
    output logic [3:0]      beats_o
);

    localparam logic [MR_W-1:0] MODE_RST = MR_W'(1);

    logic [MR_W-1:0] mode_q, ext_q;

    always_comb begin
        unique case (sel_i)
            2'b00:   ok_o = bl_code_ok(op_i[2:0]);
            2'b01:   ok_o = 1'b1;
            default: ok_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= MODE_RST;
            ext_q  <= '0;
        end else if (we_i) begin
            if (sel_i == 2'b00) mode_q <= op_i;
            if (sel_i == 2'b01) ext_q  <= op_i;
        end
    end

    always_comb begin
        mode_o  = mode_q;
        ext_o   = ext_q;
        beats_o = bl_beats(mode_q[2:0]);
    end

    // R11: the stored burst field always holds a legal code
    assert_bl_field_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bl_code_ok(mode_q[2:0]));

    // R10: a write strobe only arrives for a register that exists
    assert_sel_exists_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |-> !sel_i[1]);

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 11
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         cke_i,
    input  logic                         cs_ni,
    input  logic                         ras_ni,
    input  logic                         cas_ni,
    input  logic                         we_ni,
    input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
    input  logic [ROW_W-1:0]             addr_i,
    input  logic                         cfg_wide_col_i,
    output logic                         cmd_vld_o,
    output logic [2:0]                   cmd_o,
    output logic [$clog2(NUM_BANKS)-1:0] bank_o,
    output logic [ROW_W-1:0]             row_o,
    output logic [COL_W-1:0]             col_o,
    output logic                         auto_pre_o,
    output logic                         pre_all_o,
    output logic                         err_o,
    output logic [NUM_BANKS-1:0]         open_o,
    output logic [3:0]                   burst_len_o,
    output logic [ROW_W-1:0]             mode_o,
    output logic [ROW_W-1:0]             ext_mode_o
);

    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int CNT_W = 3;
    localparam int AP_BIT = 10;
    localparam int LO_COL = 10;

    cmd_e                 dec_cmd;
    logic                 cmd_ok;
    logic                 accept;
    logic                 reject;
    logic                 lmr_ok;
    logic                 is_rw;
    logic [NUM_BANKS-1:0] bank_idle;
    logic [NUM_BANKS-1:0] bank_ready;
    logic [ROW_W-1:0]     bank_row [NUM_BANKS];
    logic [COL_W-1:0]     col_sel;
    logic [3:0]           beats;

    ddr_cmd_decode u_decode (
        .cke_i  (cke_i),
        .cs_ni  (cs_ni),
        .ras_ni (ras_ni),
        .cas_ni (cas_ni),
        .we_ni  (we_ni),
        .cmd_o  (dec_cmd)
    );

    ddr_mode_file #(.MR_W(ROW_W)) u_mode (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (accept && (dec_cmd == CMD_LMR)),
        .sel_i   (ba_i),
        .op_i    (addr_i),
        .ok_o    (lmr_ok),
        .mode_o  (mode_o),
        .ext_o   (ext_mode_o),
        .beats_o (beats)
    );

    assign is_rw = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);

    always_comb begin
        unique case (dec_cmd)
            CMD_ACT:        cmd_ok = bank_idle[ba_i];
            CMD_RD, CMD_WR: cmd_ok = bank_ready[ba_i];
            CMD_LMR:        cmd_ok = lmr_ok;
            default:        cmd_ok = 1'b1;
        endcase
        accept = (dec_cmd != CMD_NOP) && cmd_ok;
        reject = (dec_cmd != CMD_NOP) && !cmd_ok;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba_i == BA_W'(b));
        ddr_bank_fsm #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (cke_i),
            .act_i   (accept && (dec_cmd == CMD_ACT) && hit),
            .arm_i   (accept && is_rw && addr_i[AP_BIT] && hit),
            .pre_i   (accept && (dec_cmd == CMD_PRE) && (addr_i[AP_BIT] || hit)),
            .row_i   (addr_i),
            .drain_i (beats[CNT_W:1]),
            .idle_o  (bank_idle[b]),
            .ready_o (bank_ready[b]),
            .row_o   (bank_row[b])
        );
        assign open_o[b] = !bank_idle[b];
    end

    always_comb begin
        col_sel = {1'b0, addr_i[LO_COL-1:0]};
        if (cfg_wide_col_i) col_sel[COL_W-1] = addr_i[AP_BIT+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_vld_o  <= 1'b0;
            cmd_o      <= 3'd0;
            bank_o     <= '0;
            row_o      <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            pre_all_o  <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            cmd_vld_o  <= accept;
            cmd_o      <= accept ? 3'(dec_cmd) : 3'd0;
            bank_o     <= accept ? ba_i : '0;
            row_o      <= '0;
            col_o      <= '0;
            auto_pre_o <= 1'b0;
            pre_all_o  <= 1'b0;
            err_o      <= reject;
            if (accept) begin
                unique case (dec_cmd)
                    CMD_ACT: row_o <= addr_i;
                    CMD_RD, CMD_WR: begin
                        row_o      <= bank_row[ba_i];
                        col_o      <= col_sel;
                        auto_pre_o <= addr_i[AP_BIT];
                    end
                    CMD_PRE: pre_all_o <= addr_i[AP_BIT];
                    default: ;
                endcase
            end
        end
    end

    assign burst_len_o = beats;

    // R2: a deselected edge never yields a strobe or an error
    assert_desel_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_ni |=> (!cmd_vld_o && !err_o));

    // R3: a clock-disabled edge yields nothing and freezes bank flags
    assert_cke_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cke_i |=> (!cmd_vld_o && !err_o && $stable(open_o)));

    // R9: accepted and rejected never coincide
    assert_vld_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cmd_vld_o && err_o));

    // R5: a bank only opens on an accepted ACTIVE
    assert_open_needs_act_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(open_o & ~$past(open_o))) |-> (cmd_vld_o && (cmd_o == 3'd1)));

    // R11: burst length is always 2, 4 or 8
    assert_burst_len_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(burst_len_o) && !burst_len_o[0]);

endmodule

// File: tb/ddr_cmd_tracker_tb.sv
module ddr_cmd_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic [2:0]  rcw = 3'b111;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic        wide = 1'b0;

    logic        vld, ap, pall, err;
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [12:0] row, mode, ext;
    logic [10:0] col;
    logic [3:0]  open, bl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ddr_cmd_tracker dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n),
        .ras_ni(rcw[2]), .cas_ni(rcw[1]), .we_ni(rcw[0]),
        .ba_i(ba), .addr_i(addr), .cfg_wide_col_i(wide),
        .cmd_vld_o(vld), .cmd_o(cmd), .bank_o(bank), .row_o(row), .col_o(col),
        .auto_pre_o(ap), .pre_all_o(pall), .err_o(err), .open_o(open),
        .burst_len_o(bl), .mode_o(mode), .ext_mode_o(ext)
    );

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_LMR = 3'b000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one command at a falling edge, step to the next falling edge
    task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a);
        cs_n = 1'b0; rcw = c; ba = b; addr = a;
        @(negedge clk);
        cs_n = 1'b1; rcw = 3'b111; ba = '0; addr = '0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 open", open, 0);
        chk("R12 vld", vld, 0);
        chk("R12 err", err, 0);
        chk("R12 burst", bl, 2);
        chk("R12 mode", mode, 13'h0001);
        chk("R12 ext", ext, 0);
    endtask

    task automatic t_activate();
        issue(C_ACT, 2'd1, 13'h0ABC);
        chk("R1 vld", vld, 1);
        chk("R4 act code", cmd, 1);
        chk("R1 bank", bank, 1);
        chk("R5 row", row, 13'h0ABC);
        chk("R5 open", open, 4'b0010);
        idle_cycle();
        chk("R1 quiet", vld, 0);
    endtask

    task automatic t_readwrite();
        issue(C_RD, 2'd1, 13'h0155);
        chk("R4 rd code", cmd, 2);
        chk("R6 rd row", row, 13'h0ABC);
        chk("R6 rd col", col, 11'h155);
        chk("R6 rd ap", ap, 0);
        issue(C_WR, 2'd1, 13'h0955);
        chk("R4 wr code", cmd, 3);
        chk("R6 narrow col", col, 11'h155);
        wide = 1'b1;
        issue(C_WR, 2'd1, 13'h0955);
        chk("R6 wide col", col, 11'h555);
        wide = 1'b0;
        chk("R6 still open", open, 4'b0010);
    endtask

    task automatic t_errors();
        issue(C_RD, 2'd2, 13'h0001);
        chk("R9 rd closed err", err, 1);
        chk("R9 rd closed vld", vld, 0);
        chk("R9 rd closed open", open, 4'b0010);
        issue(C_ACT, 2'd1, 13'h0111);
        chk("R9 act open err", err, 1);
        issue(C_RD, 2'd1, 13'h0000);
        chk("R9 row kept", row, 13'h0ABC);
    endtask

    task automatic t_nop();
        cs_n = 1'b1; rcw = C_ACT; ba = 2'd0; addr = 13'h0007;
        @(negedge clk);
        chk("R2 desel vld", vld, 0);
        chk("R2 desel open", open, 4'b0010);
        cs_n = 1'b0; rcw = 3'b111;
        @(negedge clk);
        chk("R4 111 nop", vld, 0);
        rcw = 3'b110;
        @(negedge clk);
        chk("R4 110 nop", vld, 0);
        cs_n = 1'b1; rcw = 3'b111;
        cke = 1'b0;
        issue(C_ACT, 2'd0, 13'h0007);
        cke = 1'b1;
        chk("R3 cke vld", vld, 0);
        chk("R3 cke open", open, 4'b0010);
    endtask

    task automatic t_precharge();
        issue(C_ACT, 2'd0, 13'h0010);
        issue(C_ACT, 2'd2, 13'h0020);
        issue(C_ACT, 2'd3, 13'h0030);
        chk("R5 all open", open, 4'b1111);
        issue(C_PRE, 2'd2, 13'h0000);
        chk("R7 single", open, 4'b1011);
        chk("R4 pre code", cmd, 4);
        chk("R7 pall low", pall, 0);
        issue(C_PRE, 2'd0, 13'h0400);
        chk("R7 all closed", open, 4'b0000);
        chk("R7 pall high", pall, 1);
        issue(C_REF, 2'd0, 13'h0000);
        chk("R4 ref code", cmd, 5);
    endtask

    task automatic t_mode();
        issue(C_LMR, 2'd0, 13'h0033);
        chk("R4 lmr code", cmd, 6);
        chk("R10 base", mode, 13'h0033);
        chk("R11 bl8", bl, 8);
        issue(C_LMR, 2'd1, 13'h0002);
        chk("R10 ext", ext, 13'h0002);
        chk("R10 base kept", mode, 13'h0033);
        issue(C_LMR, 2'd2, 13'h1111);
        chk("R10 bad sel err", err, 1);
        chk("R10 bad sel ext", ext, 13'h0002);
        issue(C_LMR, 2'd0, 13'h0005);
        chk("R11 bad bl err", err, 1);
        chk("R11 bad bl kept", mode, 13'h0033);
        issue(C_LMR, 2'd0, 13'h0022);
        chk("R11 bl4", bl, 4);
        issue(C_LMR, 2'd0, 13'h0033);
    endtask

    task automatic t_autopre8();
        issue(C_ACT, 2'd3, 13'h0123);
        issue(C_RD, 2'd3, 13'h0400);      // edge N, burst 8
        chk("R6 ap flag", ap, 1);
        issue(C_RD, 2'd3, 13'h0000);      // edge N+1
        chk("R8 rd while draining", err, 1);
        idle_cycle();                      // N+2
        idle_cycle();                      // N+3
        chk("R8 open at N+3", open[3], 1);
        idle_cycle();                      // N+4
        chk("R8 closed at N+4", open[3], 0);
    endtask

    task automatic t_autopre2();
        issue(C_LMR, 2'd0, 13'h0011);
        chk("R11 bl2", bl, 2);
        issue(C_ACT, 2'd0, 13'h0044);
        issue(C_WR, 2'd0, 13'h0400);      // edge N, burst 2
        cke = 1'b0;
        idle_cycle();                      // N+1 frozen
        chk("R3 drain frozen", open[0], 1);
        cke = 1'b1;
        idle_cycle();                      // N+2
        chk("R8 bl2 closed", open[0], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_activate();
        t_readwrite();
        t_errors();
        t_nop();
        t_precharge();
        t_mode();
        t_autopre8();
        t_autopre2();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule